// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer with Watchdog Reset Request

The block is a register-mapped timer built around one 16-bit down-counter fed by a power-of-two prescaler. Software reaches it through a simple 32-bit register bus. One register holds the reload value, one register configures the timer, one register reads back the live count, and one status register holds the watchdog reset cause. Four counting behaviours share the same counter: a free-running wrap-around count, a periodic count that reloads itself, a one-shot timeout that stops itself, and a watchdog.

In watchdog mode, software must keep writing the reload register. Each such write is a keep-alive: it restarts both the count and the prescaler. If the count runs out first, the block raises a one-clock reset request for the system reset controller. In the same clock it sets a sticky cause bit. The system reset input does not clear that bit, so firmware can read it after the reboot to learn why the chip restarted. Only the separate power-on reset input clears it.

The counter "hits zero" on a prescaler tick taken while the count is 1 or 0. A reload value L therefore gives an expiry L ticks after the count was loaded or the timer was enabled. A value of 0 behaves like 1.

Top module: `tick_guard_timer`

## Requirements
- R1: While `rst` or `por` is high, and afterwards until the first write, the reload register reads 0x0000FFFF. The count reads 0x0000FFFF, the control register reads 0, and both `expire_pulse` and `rst_req` are low.
- R2: The register map uses these byte offsets:
  - 0x00: reload value, bits 15:0.
  - 0x04: live count, read-only, bits 15:0.
  - 0x08: control. Bit 7 is run enable, bits 5:4 are the mode, bits 3:0 are the prescale code.
  - 0x38: status. Bit 1 is the watchdog cause.
  Unused bits and unmapped offsets read 0, and writes to 0x04 and 0x38 are ignored.
- R3: Prescale code n gives one counter tick every 2^(n+1) enabled clocks. The prescaler restarts when the timer is enabled and on every reload write. The first tick lands 2^(n+1) clocks after the enabling write.
- R4: With run enable at 0 the count holds its value.
- R5: A write to offset 0x00 loads the written value into the count in the same clock edge, in every mode. In watchdog mode this write is the keep-alive.
- R6: Mode 0 (free-running): the count steps down once per tick and wraps from 0 to 0xFFFF. It produces no pulse.
- R7: Mode 1 (periodic): on zero the count reloads from the reload register and `expire_pulse` is high for one clock. With reload value L, pulses are L·2^(n+1) clocks apart.
- R8: Mode 2 (one-shot timeout): on zero `expire_pulse` is high for one clock. The count then rests at 0 and the run enable bit clears itself.
- R9: Mode 3 (watchdog): on zero `rst_req` is high for exactly one clock and `expire_pulse` stays low. The count reloads from the reload register.
- R10: A watchdog expiry sets status bit 1 in the same clock as `rst_req`. The bit survives `rst` and writes, and only `por` clears it.
- R11: A read access updates `bus_rdata` at the next clock edge. `bus_rdata` keeps its value when no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high; leaves the cause bit alone |
| por | input | 1 | Synchronous power-on reset, active high; clears everything |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| expire_pulse | output | 1 | One-clock pulse on periodic or timeout expiry |
| rst_req | output | 1 | One-clock system reset request on watchdog expiry |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a 4-bit prescale code, a 32-bit data bus and 8-bit offsets. Prescale codes 0 to 3 make each tick take 2 to 16 clocks, so hundreds of expiries, keep-alives, wraps and self-stops fit in a short run. Code 15 (divide by 65536) is reached once with a reload of 1, which confirms the widest prescaler path end to end.

// File: rtl/tgt_pkg.sv
package tgt_pkg;
  localparam int unsigned CNT_W_DEF  = 16;
  localparam int unsigned CODE_W_DEF = 4;
  localparam int unsigned DATA_W_DEF = 32;
  localparam int unsigned ADDR_W_DEF = 8;

  // byte offsets of the register window
  localparam logic [7:0] OFF_LOAD  = 8'h00;
  localparam logic [7:0] OFF_COUNT = 8'h04;
  localparam logic [7:0] OFF_CTRL  = 8'h08;
  localparam logic [7:0] OFF_STAT  = 8'h38;

  localparam int unsigned CAUSE_BIT = 1;

  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_ONESHOT  = 2'd2,
    MODE_WATCHDOG = 2'd3
  } tmode_e;
endpackage

// File: rtl/tgt_prescale.sv
module tgt_prescale #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_any,
  input  logic              en,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int unsigned PS_W = 1 << CODE_W;

  logic [PS_W-1:0] pcnt;
  logic [PS_W-1:0] mask;

  // low (code+1) bits of the mask set: tick every 2^(code+1) clocks
  for (genvar g = 0; g < PS_W; g++) begin : g_mask
    assign mask[g] = (code >= CODE_W'(g));
  end

  assign tick = en && !restart && ((pcnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst_any || !en || restart) pcnt <= '0;
    else                           pcnt <= pcnt + 1'b1;
  end

  // shortest division is 2, so ticks never come back to back
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst_any)
    tick |=> !tick);
  // a restart leaves the prescaler at its start, one full period away
  assert_restart_no_tick_R3: assert property (@(posedge clk) disable iff (rst_any)
    restart |=> !tick);
endmodule

// File: rtl/tgt_count.sv
module tgt_count
  import tgt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_any,
  input  logic             tick,
  input  tmode_e           mode,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_wdata,
  input  logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] count_q,
  output logic             expire_q,
  output logic             rstreq_q,
  output logic             hw_stop,
  output logic             wd_fire
);
  logic             zero_hit;
  logic [CNT_W-1:0] cnt_n;
  logic             exp_n;
  logic             rr_n;

  // count of 1 steps into zero; a count of 0 expires at once
  assign zero_hit = tick && (count_q[CNT_W-1:1] == '0);
  assign hw_stop  = zero_hit && (mode == MODE_ONESHOT);
  assign wd_fire  = zero_hit && (mode == MODE_WATCHDOG);

  always_comb begin
    cnt_n = count_q;
    exp_n = 1'b0;
    rr_n  = 1'b0;
    if (load_wr) begin
      cnt_n = load_wdata;
    end else if (tick) begin
      case (mode)
        MODE_FREE: cnt_n = count_q - 1'b1;
        MODE_PERIODIC: begin
          if (zero_hit) begin
            cnt_n = load_q;
            exp_n = 1'b1;
          end else begin
            cnt_n = count_q - 1'b1;
          end
        end
        MODE_ONESHOT: begin
          if (zero_hit) begin
            cnt_n = '0;
            exp_n = 1'b1;
          end else begin
            cnt_n = count_q - 1'b1;
          end
        end
        MODE_WATCHDOG: begin
          if (zero_hit) begin
            cnt_n = load_q;
            rr_n  = 1'b1;
          end else begin
            cnt_n = count_q - 1'b1;
          end
        end
        default: cnt_n = count_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      count_q  <= '1;
      expire_q <= 1'b0;
      rstreq_q <= 1'b0;
    end else begin
      count_q  <= cnt_n;
      expire_q <= exp_n;
      rstreq_q <= rr_n;
    end
  end

  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (rst_any)
    (!tick && !load_wr) |=> $stable(count_q));
  assert_reload_write_R5: assert property (@(posedge clk) disable iff (rst_any)
    load_wr |=> (count_q == $past(load_wdata)));
  assert_free_wrap_R6: assert property (@(posedge clk) disable iff (rst_any)
    (tick && !load_wr && mode == MODE_FREE && count_q == '0) |=> (count_q == '1));
  assert_rstreq_one_clk_R9: assert property (@(posedge clk) disable iff (rst_any)
    rstreq_q |=> !rstreq_q);
  assert_pulse_exclusive_R9: assert property (@(posedge clk) disable iff (rst_any)
    !(rstreq_q && expire_q));
endmodule

// File: rtl/tgt_regs.sv
module tgt_regs
  import tgt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_any,
  input  logic              por,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              hw_stop,
  input  logic              wd_fire,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CNT_W-1:0]  load_q,
  output logic              load_wr,
  output logic              en_q,
  output tmode_e            mode_q,
  output logic [CODE_W-1:0] code_q,
  output logic              cause_q
);
  // control layout follows the code width: code, then mode, one spare bit, then enable
  localparam int unsigned MODE_L = CODE_W;
  localparam int unsigned EN_L   = CODE_W + 3;
  localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFF_LOAD);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);

  logic              ctrl_wr;
  logic              rd_acc;
  logic [DATA_W-1:0] rd_next;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];
  assign load_wr = bus_en && bus_we && (bus_addr == A_LOAD);
  assign ctrl_wr = bus_en && bus_we && (bus_addr == A_CTRL);
  assign rd_acc  = bus_en && !bus_we;

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      A_LOAD:  rd_next[CNT_W-1:0] = load_q;
      A_COUNT: rd_next[CNT_W-1:0] = count_i;
      A_CTRL: begin
        rd_next[EN_L]          = en_q;
        rd_next[MODE_L +: 2]   = mode_q;
        rd_next[CODE_W-1:0]    = code_q;
      end
      A_STAT:  rd_next[CAUSE_BIT] = cause_q;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      load_q <= '1;
    end else if (load_wr) begin
      load_q <= bus_wdata[CNT_W-1:0];
    end
  end

  // a software write in the same clock takes precedence over the self-stop
  always_ff @(posedge clk) begin
    if (rst_any) begin
      en_q   <= 1'b0;
      mode_q <= MODE_FREE;
      code_q <= '0;
    end else if (ctrl_wr) begin
      en_q   <= bus_wdata[EN_L];
      mode_q <= tmode_e'(bus_wdata[MODE_L +: 2]);
      code_q <= bus_wdata[CODE_W-1:0];
    end else if (hw_stop) begin
      en_q   <= 1'b0;
    end
  end

  // cause bit: power-on reset only
  always_ff @(posedge clk) begin
    if (por)          cause_q <= 1'b0;
    else if (wd_fire) cause_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_any)     bus_rdata <= '0;
    else if (rd_acc) bus_rdata <= rd_next;
  end

  assert_stop_clears_en_R8: assert property (@(posedge clk) disable iff (rst_any)
    (hw_stop && !ctrl_wr) |=> !en_q);
  assert_cause_on_fire_R10: assert property (@(posedge clk) disable iff (por)
    wd_fire |=> cause_q);
  assert_cause_sticky_R10: assert property (@(posedge clk) disable iff (por)
    cause_q |=> cause_q);
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst_any)
    !rd_acc |=> $stable(bus_rdata));
endmodule

// File: rtl/tick_guard_timer.sv
module tick_guard_timer
  import tgt_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned CNT_W  = CNT_W_DEF,
  parameter int unsigned CODE_W = CODE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              expire_pulse,
  output logic              rst_req
);
  logic              rst_any;
  logic [CNT_W-1:0]  load_q;
  logic              load_wr;
  logic              en_q;
  tmode_e            mode_q;
  logic [CODE_W-1:0] code_q;
  logic              cause_q;
  logic [CNT_W-1:0]  count_q;
  logic              tick;
  logic              hw_stop;
  logic              wd_fire;

  assign rst_any = rst | por;

  tgt_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CODE_W(CODE_W)
  ) u_regs (
    .clk(clk), .rst_any(rst_any), .por(por),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .count_i(count_q), .hw_stop(hw_stop), .wd_fire(wd_fire),
    .bus_rdata(bus_rdata), .load_q(load_q), .load_wr(load_wr),
    .en_q(en_q), .mode_q(mode_q), .code_q(code_q), .cause_q(cause_q)
  );

  tgt_prescale #(.CODE_W(CODE_W)) u_pre (
    .clk(clk), .rst_any(rst_any), .en(en_q), .restart(load_wr),
    .code(code_q), .tick(tick)
  );

  tgt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_any(rst_any), .tick(tick), .mode(mode_q),
    .load_wr(load_wr), .load_wdata(bus_wdata[CNT_W-1:0]), .load_q(load_q),
    .count_q(count_q), .expire_q(expire_pulse), .rstreq_q(rst_req),
    .hw_stop(hw_stop), .wd_fire(wd_fire)
  );

  assert_req_has_cause_R10: assert property (@(posedge clk) disable iff (por)
    rst_req |-> cause_q);
endmodule

// File: tb/tb_tick_guard_timer.sv
`timescale 1ns/1ps
module tb_tick_guard_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        por = 1'b1;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        expire_pulse;
  logic        rst_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_guard_timer dut (
    .clk(clk), .rst(rst), .por(por), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .expire_pulse(expire_pulse), .rst_req(rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  // counts negedges until the chosen output is seen; 'other' counts the opposite one
  task automatic wait_sig(input bit use_rr, input int limit, output int n, output int other);
    n = 0; other = 0;
    do begin
      @(negedge clk);
      n++;
      if (use_rr ? expire_pulse : rst_req) other++;
    end while (!(use_rr ? rst_req : expire_pulse) && n < limit);
  endtask

  function automatic logic [31:0] cw(input bit en, input int mode, input int code);
    logic [31:0] w;
    w = '0;
    w[7] = en; w[5:4] = mode[1:0]; w[3:0] = code[3:0];
    return w;
  endfunction

  function automatic int dper(input int code);
    return 1 << (code + 1);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n, oth;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0; por = 1'b0;

    // R1 reset state
    chk("R1 expire low", {31'b0, expire_pulse}, 0);
    chk("R1 rst_req low", {31'b0, rst_req}, 0);
    rd(8'h00, d); chk("R1 load", d, 32'h0000FFFF);
    rd(8'h04, d); chk("R1 count", d, 32'h0000FFFF);
    rd(8'h08, d); chk("R1 ctrl", d, 0);
    rd(8'h38, d); chk("R1 status", d, 0);

    // R2 map, unused bits, read-only offsets
    wr(8'h08, 32'hFFFFFF3F);
    rd(8'h08, d); chk("R2 ctrl unused bits", d, 32'h0000003F);
    wr(8'h00, 32'hFFFF1234);
    rd(8'h00, d); chk("R2 load width", d, 32'h00001234);
    rd(8'h04, d); chk("R5 count loaded", d, 32'h00001234);
    wr(8'h04, 32'h0);
    rd(8'h04, d); chk("R2 count read-only", d, 32'h00001234);
    wr(8'h38, 32'hFFFFFFFF);
    rd(8'h38, d); chk("R2 status write ignored", d, 0);
    rd(8'h10, d); chk("R2 unmapped", d, 0);
    wr(8'h08, 0);

    // R7 periodic: load 3, code 0 -> every 6 clocks
    wr(8'h00, 3);
    wr(8'h08, cw(1, 1, 0));
    wait_sig(0, 100, n, oth); chk("R7 first period", n, 6);
    @(negedge clk); chk("R7 one clock", {31'b0, expire_pulse}, 0);
    wait_sig(0, 100, n, oth); chk("R7 second period", n, 5);
    wr(8'h08, 0);

    // R8 one-shot: load 2, code 1 -> 8 clocks, then self-stop
    wr(8'h00, 2);
    wr(8'h08, cw(1, 2, 1));
    wait_sig(0, 100, n, oth); chk("R8 expiry time", n, 8);
    wait_sig(0, 30, n, oth); chk("R8 no second pulse", n, 30);
    rd(8'h08, d); chk("R8 enable cleared", d, cw(0, 2, 1));
    rd(8'h04, d); chk("R8 count rests at zero", d, 0);

    // R6 free-run wrap: load 1, code 0, disable at E0+6 -> 3 steps -> FFFE
    wr(8'h00, 1);
    wr(8'h08, cw(1, 0, 0));
    oth = 0;
    repeat (5) begin @(negedge clk); if (expire_pulse) oth++; end
    wr(8'h08, cw(0, 0, 0));
    chk("R6 no pulse", oth, 0);
    rd(8'h04, d); chk("R6 wrap", d, 32'h0000FFFE);
    repeat (10) @(negedge clk);
    rd(8'h04, d); chk("R4 held when disabled", d, 32'h0000FFFE);

    // R9/R5 watchdog with keep-alive: load 4, code 1 -> 16 clocks
    wr(8'h00, 4);
    wr(8'h08, cw(1, 3, 1));
    repeat (10) @(negedge clk);
    chk("R5 no early reset", {31'b0, rst_req}, 0);
    wr(8'h00, 4);
    wait_sig(1, 100, n, oth); chk("R5 ping restarts", n, 16);
    chk("R9 expire stays low", oth, 0);
    @(negedge clk); chk("R9 one clock", {31'b0, rst_req}, 0);
    wr(8'h08, 0);
    rd(8'h38, d); chk("R10 cause set", d, 32'h2);

    // R10 cause survives system reset, cleared by power-on reset
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    rd(8'h38, d); chk("R10 survives rst", d, 32'h2);
    rd(8'h00, d); chk("R1 load after rst", d, 32'h0000FFFF);
    wr(8'h38, 0);
    rd(8'h38, d); chk("R10 write ignored", d, 32'h2);
    por = 1'b1; repeat (2) @(negedge clk); por = 1'b0;
    rd(8'h38, d); chk("R10 cleared by por", d, 0);

    // R11 rdata holds without a read
    rd(8'h00, d);
    repeat (4) @(negedge clk);
    chk("R11 rdata hold", bus_rdata, 32'h0000FFFF);

    // random expiries in modes 1..3 (R3, R7, R8, R9)
    for (int i = 0; i < 24; i++) begin
      int l, code, mode;
      l = 1 + int'($urandom_range(23));
      code = int'($urandom_range(3));
      mode = 1 + int'($urandom_range(2));
      wr(8'h00, l);
      wr(8'h08, cw(1, mode, code));
      wait_sig(mode == 3, 1000, n, oth);
      chk("R3 expiry after L*2^(n+1)", n, l * dper(code));
      chk("R9 no opposite pulse", oth, 0);
      if (mode == 2) begin
        @(negedge clk);
        rd(8'h08, d); chk("R8 self-stop", d, cw(0, 2, code));
      end
      wr(8'h08, 0);
    end

    // random free-running stop points (R3, R6)
    for (int i = 0; i < 12; i++) begin
      int l, code, w;
      logic [15:0] e;
      l = int'($urandom_range(40));
      code = int'($urandom_range(2));
      w = int'($urandom_range(60));
      wr(8'h00, l);
      wr(8'h08, cw(1, 0, code));
      repeat (w) @(negedge clk);
      wr(8'h08, 0);
      e = 16'(l - (w + 1) / dper(code));
      rd(8'h04, d); chk("R6 free count", d, {16'b0, e});
    end

    // R3 widest prescale: code 15, load 1 -> 65536 clocks
    wr(8'h00, 1);
    wr(8'h08, cw(1, 3, 15));
    wait_sig(1, 70000, n, oth); chk("R3 divide by 65536", n, 65536);
    wr(8'h08, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule